// File: doc/BRIEF.md
# Adaptive Minimal Hypercube Route Selector

This block makes the routing decision for one node of a binary hypercube network of dimension `DIM`. Every node carries a `DIM`-bit label and owns one link per dimension; link `i` leads to the neighbour whose label differs from the local one in bit `i` only. When a packet header arrives, the block compares its destination label with the local label. If the two match, the packet is handed to the local processing element. Otherwise the block picks one outgoing link that corrects one differing bit, so that every hop brings the packet one step closer.

Any differing dimension is a legal minimal hop. The selector chooses among them at run time using a busy flag and a fault flag per link, steering around congested or broken links. The search starts at a rotating pointer so that load spreads across equally good links. If no usable minimal link exists, it reports a stall and selects nothing. It also reports how many hops remain.

The decision is registered: it appears one clock after the header-valid strobe and lasts one cycle per header. A small state machine holds the outcome of the last cycle. Its states are `RS_IDLE` (no header), `RS_FWD` (a link was granted), `RS_LOCAL` (delivered locally) and `RS_STALL` (no usable candidate). Every state may move to every state on each clock. The transition taken is chosen by the inputs of that cycle: no strobe leads to `RS_IDLE`; a strobe with equal labels leads to `RS_LOCAL`; a strobe with no free, sound candidate leads to `RS_STALL`; any other strobe leads to `RS_FWD`.

Top module: `hcube_route_sel`

## Requirements
- R1: During and right after reset `out_valid`, `port_sel`, `deliver_local`, `stall` and `hops_left` are all zero, and the rotation pointer is 0.
- R2: `out_valid` is high in the cycle after every cycle with `hdr_valid` high, and low in the cycle after every cycle with `hdr_valid` low.
- R3: When the destination label equals the local label, the result has `deliver_local`=1, `stall`=0 and `port_sel`=0.
- R4: With each result, `hops_left` equals the number of bit positions in which the destination and local labels differ.
- R5: `port_sel` bit `i` selects the link of dimension `i` (label bit `i`). It is at most one-hot, and a set bit is always a dimension where the labels differ.
- R6: A link whose `link_busy` or `link_fault` bit is set is never selected. If every differing dimension is busy or faulty, the result has `stall`=1 and `port_sel`=0.
- R7: The granted dimension is the first usable candidate found when searching upward from the rotation pointer, wrapping from `DIM-1` to 0. The pointer is 0 after reset. After a grant on dimension k it becomes k+1, or 0 when k=`DIM-1`. Local delivery, stalls and idle cycles leave it unchanged.
- R8: Busy or fault flags on dimensions where the labels agree have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | A header is present this cycle |
| dest_label | input | DIM | Destination node label of the header |
| local_label | input | DIM | Label of this node |
| link_busy | input | DIM | Per-dimension link congested flag |
| link_fault | input | DIM | Per-dimension link broken flag |
| out_valid | output | 1 | A decision is presented this cycle |
| port_sel | output | DIM | One-hot selected outgoing dimension |
| deliver_local | output | 1 | Packet is for the local element |
| stall | output | 1 | No usable minimal link this cycle |
| hops_left | output | $clog2(DIM+1) | Remaining hop count |

## Verification
The same source and destination pair is sent several times in a row with all links free. This shows the rotation walking across the candidates and skipping dimensions where the labels agree, which separates a rotating search from a fixed lowest-bit choice. Patterns with busy and faulty candidates tell apart a correct detour, a correct stall and the wrong selection of a blocked link. Patterns that set flags only on non-candidate links show whether those flags are wrongly taken into account. Equal labels, all-bits-differ labels and a reset in the middle of a sequence cover local delivery, the widest hop count and the return of the pointer to zero.

// File: rtl/hc_route_pkg.sv
package hc_route_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_FWD   = 2'd1,
        RS_LOCAL = 2'd2,
        RS_STALL = 2'd3
    } rsel_state_t;
endpackage

// File: rtl/hc_popcount.sv
module hc_popcount #(
    parameter int W  = 4,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_in,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(bits_in[i]);
        end
    end
endmodule

// File: rtl/hc_rr_pick.sv
module hc_rr_pick #(
    parameter int DIM = 4,
    parameter int PW  = (DIM > 1) ? $clog2(DIM) : 1
) (
    input  logic [DIM-1:0] elig,
    input  logic [PW-1:0]  start,
    output logic           found,
    output logic [PW-1:0]  idx
);
    int pos;

    // Walk the offsets from the top down so the smallest offset wins.
    always_comb begin
        found = |elig;
        idx   = '0;
        pos   = 0;
        for (int off = DIM - 1; off >= 0; off--) begin
            pos = int'(start) + off;
            if (pos >= DIM) pos = pos - DIM;
            if (elig[pos]) idx = PW'(pos);
        end
    end
endmodule

// File: rtl/hcube_route_sel.sv
module hcube_route_sel
    import hc_route_pkg::*;
#(
    parameter int DIM = 4,
    parameter int HW  = $clog2(DIM + 1),
    parameter int PW  = (DIM > 1) ? $clog2(DIM) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hdr_valid,
    input  logic [DIM-1:0] dest_label,
    input  logic [DIM-1:0] local_label,
    input  logic [DIM-1:0] link_busy,
    input  logic [DIM-1:0] link_fault,
    output logic           out_valid,
    output logic [DIM-1:0] port_sel,
    output logic           deliver_local,
    output logic           stall,
    output logic [HW-1:0]  hops_left
);
    localparam logic [PW-1:0] LAST_DIM = PW'(DIM - 1);

    rsel_state_t    state_q, state_d;
    logic [DIM-1:0] diff_bits, usable;
    logic [HW-1:0]  hop_cnt;
    logic           any_usable;
    logic [PW-1:0]  pick_idx, ptr_q;
    logic [DIM-1:0] sel_q;
    logic [HW-1:0]  hops_q;

    assign diff_bits = dest_label ^ local_label;
    assign usable    = diff_bits & ~(link_busy | link_fault);

    hc_popcount #(.W(DIM), .CW(HW)) u_hops (
        .bits_in (diff_bits),
        .count   (hop_cnt)
    );

    hc_rr_pick #(.DIM(DIM), .PW(PW)) u_pick (
        .elig  (usable),
        .start (ptr_q),
        .found (any_usable),
        .idx   (pick_idx)
    );

    // Next-state choice
    always_comb begin
        if (!hdr_valid)          state_d = RS_IDLE;
        else if (diff_bits == '0) state_d = RS_LOCAL;
        else if (!any_usable)    state_d = RS_STALL;
        else                     state_d = RS_FWD;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Registered datapath: selection, hop count, rotation pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            hops_q <= '0;
            ptr_q  <= '0;
        end else begin
            hops_q <= hdr_valid ? hop_cnt : '0;
            if (state_d == RS_FWD) begin
                sel_q <= DIM'(1) << pick_idx;
                ptr_q <= (pick_idx == LAST_DIM) ? '0 : pick_idx + PW'(1);
            end else begin
                sel_q <= '0;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        out_valid     = 1'b0;
        deliver_local = 1'b0;
        stall         = 1'b0;
        port_sel      = '0;
        unique case (state_q)
            RS_IDLE:  ;
            RS_FWD: begin
                out_valid = 1'b1;
                port_sel  = sel_q;
            end
            RS_LOCAL: begin
                out_valid     = 1'b1;
                deliver_local = 1'b1;
            end
            RS_STALL: begin
                out_valid = 1'b1;
                stall     = 1'b1;
            end
            default: ;
        endcase
    end

    assign hops_left = hops_q;
endmodule

// File: rtl/hc_route_chk.sv
module hc_route_chk #(
    parameter int DIM = 4,
    parameter int HW  = $clog2(DIM + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hdr_valid,
    input logic [DIM-1:0] dest_label,
    input logic [DIM-1:0] local_label,
    input logic [DIM-1:0] link_busy,
    input logic [DIM-1:0] link_fault,
    input logic           out_valid,
    input logic [DIM-1:0] port_sel,
    input logic           deliver_local,
    input logic           stall,
    input logic [HW-1:0]  hops_left
);
    // R2
    valid_follows_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> out_valid);
    // R2
    idle_follows_nohdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> (!out_valid && port_sel == '0 && !stall && !deliver_local));
    // R3
    local_when_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && dest_label == local_label) |=>
            (deliver_local && !stall && port_sel == '0));
    // R4
    hops_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> (int'(hops_left) == $countones($past(dest_label ^ local_label))));
    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sel));
    // R5
    sel_minimal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> ((port_sel & ~$past(dest_label ^ local_label)) == '0));
    // R6
    sel_not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> ((port_sel & $past(link_busy | link_fault)) == '0));
    // R6
    stall_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (port_sel == '0 && !deliver_local));
endmodule

bind hcube_route_sel hc_route_chk #(.DIM(DIM), .HW(HW)) u_chk (.*);

// File: tb/hcube_route_sel_test.sv
module hcube_route_sel_test;
    localparam int DIM = 4;
    localparam int HW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           hdr_valid = 1'b0;
    logic [DIM-1:0] dest_label = '0, local_label = '0, link_busy = '0, link_fault = '0;
    logic           out_valid, deliver_local, stall;
    logic [DIM-1:0] port_sel;
    logic [HW-1:0]  hops_left;

    int n_chk = 0;
    int n_bad = 0;

    hcube_route_sel #(.DIM(DIM)) uut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid),
        .dest_label(dest_label), .local_label(local_label),
        .link_busy(link_busy), .link_fault(link_fault),
        .out_valid(out_valid), .port_sel(port_sel),
        .deliver_local(deliver_local), .stall(stall), .hops_left(hops_left)
    );

    always #5 clk = ~clk;

    // local, dest, busy, fault, exp_sel, exp_local, exp_stall, exp_hops
    // Rotation pointer evolution is worked out by hand (starts at 0).
    localparam int NV = 13;
    localparam logic [24:0] VEC [NV] = '{
        {4'b0000, 4'b1011, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0, 3'd3}, // ptr0 -> dim0 (R7)
        {4'b0000, 4'b1011, 4'b0000, 4'b0000, 4'b0010, 1'b0, 1'b0, 3'd3}, // ptr1 -> dim1 (R7)
        {4'b0000, 4'b1011, 4'b0000, 4'b0000, 4'b1000, 1'b0, 1'b0, 3'd3}, // ptr2 skips dim2 (R5)
        {4'b0101, 4'b0101, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 3'd0}, // local (R3)
        {4'b0000, 4'b1011, 4'b0001, 4'b0000, 4'b0010, 1'b0, 1'b0, 3'd3}, // busy detour (R6)
        {4'b0110, 4'b1001, 4'b0100, 4'b1000, 4'b0001, 1'b0, 1'b0, 3'd4}, // wrap past blocked (R6)
        {4'b0011, 4'b0001, 4'b0010, 4'b0000, 4'b0000, 1'b0, 1'b1, 3'd1}, // busy only cand (R6)
        {4'b0011, 4'b0001, 4'b0000, 4'b0010, 4'b0000, 1'b0, 1'b1, 3'd1}, // faulty only cand (R6)
        {4'b0011, 4'b0001, 4'b1101, 4'b0000, 4'b0010, 1'b0, 1'b0, 3'd1}, // non-cand flags (R8)
        {4'b1111, 4'b0000, 4'b0000, 4'b1011, 4'b0100, 1'b0, 1'b0, 3'd4}, // one sound link (R6)
        {4'b1000, 4'b1001, 4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b0, 3'd1}, // ptr3 wraps (R7)
        {4'b0000, 4'b1100, 4'b0000, 4'b0000, 4'b0100, 1'b0, 1'b0, 3'd2}, // ptr1 -> dim2 (R7)
        {4'b0000, 4'b1100, 4'b0000, 4'b0000, 4'b1000, 1'b0, 1'b0, 3'd2}  // ptr3 -> dim3 (R7)
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [DIM-1:0] lo, input logic [DIM-1:0] de,
                         input logic [DIM-1:0] bu, input logic [DIM-1:0] fa);
        @(negedge clk);
        local_label = lo; dest_label = de; link_busy = bu; link_fault = fa;
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 port_sel", 32'(port_sel), 0);
        chk("R1 flags", {30'd0, deliver_local, stall}, 0);
        chk("R1 hops", 32'(hops_left), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'(out_valid), 0);

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][24:21], VEC[v][20:17], VEC[v][16:13], VEC[v][12:9]);
            chk("R2 valid", 32'(out_valid), 1);
            chk("R5 R6 R7 port_sel", 32'(port_sel), 32'(VEC[v][8:5]));
            chk("R3 deliver_local", 32'(deliver_local), 32'(VEC[v][4]));
            chk("R6 stall", 32'(stall), 32'(VEC[v][3]));
            chk("R4 hops", 32'(hops_left), 32'(VEC[v][2:0]));
            @(negedge clk);
            chk("R2 idle after", 32'(out_valid), 0);
        end

        // R2: back-to-back headers keep out_valid high; pointer now 0
        @(negedge clk);
        local_label = 4'b0000; dest_label = 4'b0011; link_busy = '0; link_fault = '0;
        hdr_valid = 1'b1;
        @(negedge clk);
        chk("R2 b2b first", 32'(out_valid), 1);
        chk("R7 b2b first sel", 32'(port_sel), 32'h1);
        @(negedge clk);
        hdr_valid = 1'b0;
        chk("R2 b2b second", 32'(out_valid), 1);
        chk("R7 b2b second sel", 32'(port_sel), 32'h2);

        // R7: stall leaves pointer alone (pointer 2 now)
        drive(4'b0000, 4'b0100, 4'b0100, 4'b0000);
        chk("R6 stall dim2", 32'(stall), 1);
        drive(4'b0000, 4'b1111, 4'b0000, 4'b0000);
        chk("R7 ptr kept after stall", 32'(port_sel), 32'h4);

        // R1: mid-run reset returns pointer to 0 (pointer 3 now)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset valid", 32'(out_valid), 0);
        rst_n = 1'b1;
        drive(4'b0000, 4'b1111, 4'b0000, 4'b0000);
        chk("R1 R7 ptr cleared", 32'(port_sel), 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule